// File: doc/BRIEF.md
# Double-Buffered IN Endpoint Transmit Controller

This block runs one device-side IN endpoint that has two payload banks. Firmware writes bytes into whichever bank is currently free and then arms that bank with a ready strobe. The banks are filled and armed strictly in turn, starting with bank 0. On the bus side, each host IN request is answered in one of two ways. If the oldest armed bank exists, the block streams that bank's payload and then waits for the host's verdict. If no bank is armed, the block signals a NAK.

Because there are two banks, firmware can fill and arm one bank while the other is on the wire. A bank is only freed when the host acknowledges it. When that happens, a sticky transmit-done flag rises and drives the interrupt line. Firmware may drop the flag only after it has armed a further bank. A missing acknowledgement leaves the bank armed, so the next IN request sends the same payload again.

Top module: `pingpong_in_ep`

## Requirements
- R1: Byte writes land in the fill bank at consecutive positions. The fill bank starts at 0 and toggles after every accepted arm. The byte count is captured when the bank is armed. Writes past 64 bytes are dropped, and so are writes while the fill bank is armed.
- R2: An accepted arm sets the fill bank's bit in `bankReady` (bit 0 is bank 0, bit 1 is bank 1) on the next cycle. Out of reset, `bankReady` is 0, `irq` is 0, `armOverflow` is 0 and `txValid` is 0.
- R3: An arm strobe while both banks are armed is ignored: `bankReady` and the stored payloads keep their values. In that case `armOverflow` goes to 1 and stays at 1 until reset.
- R4: An IN request while a bank is armed gives a one-cycle `txStart` on the next cycle, with `txLen` holding that bank's byte count. The bytes then follow on consecutive `txValid` cycles in write order, starting in the same cycle as `txStart`. Banks are sent in the order they were armed.
- R5: An IN request while no bank is armed gives a one-cycle `nakPulse` on the next cycle, and no `txStart`.
- R6: A bank armed with zero bytes gives `txStart` with `txLen` = 0 and no `txValid` cycle.
- R7: A host ACK after the payload clears that bank's `bankReady` bit and sets `txDone` and `irq` on the next cycle.
- R8: A host timeout after the payload leaves the bank armed and `txDone` unchanged. The next IN request sends the same bytes again.
- R9: A clear strobe lowers `txDone` only if an arm has been accepted since `txDone` last rose (an arm in the same cycle as the completion counts). Otherwise the clear is ignored and `irq` stays at 1.
- R10: If a completion and a clear strobe fall in the same cycle, `txDone` stays at 1, and a later clear needs a fresh arm before it takes effect.
- R11: Firmware can fill and arm the free bank while the other bank is streaming. Both bits of `bankReady` then read 1 during the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fwWrEn | input | 1 | Firmware byte write strobe |
| fwWrData | input | 8 | Firmware byte |
| fwPktReady | input | 1 | Firmware arm strobe for the fill bank |
| fwClearTxDone | input | 1 | Firmware request to clear the transmit-done flag |
| busInReq | input | 1 | Host IN request strobe |
| busAck | input | 1 | Host acknowledged the last payload |
| busTimeout | input | 1 | Host gave no acknowledgement |
| txStart | output | 1 | First cycle of a data packet |
| txValid | output | 1 | `txData` carries a payload byte |
| txData | output | 8 | Payload byte |
| txLen | output | 7 | Byte count of the bank being sent, valid with `txStart` |
| nakPulse | output | 1 | Answer NAK to the current request |
| bankReady | output | 2 | Armed state per bank |
| txDone | output | 1 | Sticky transmit-complete flag |
| irq | output | 1 | Endpoint interrupt, follows `txDone` |
| armOverflow | output | 1 | Sticky: an arm was refused because both banks were armed |

## Verification
Two collisions can happen in one cycle. In the first, the host ACK that raises transmit-done meets the firmware clear of that flag. The bench drives both strobes on the same edge, after firmware has armed the next bank. It expects `irq` to still read 1 afterwards, and it expects a second, lone clear to be ignored as well. In the second, firmware arms the idle bank while the other bank is streaming. The scoreboard confirms that the stream's bytes are undisturbed, that both ready bits read 1 mid-stream, and that the newly armed bank goes out next with its own bytes.

// File: rtl/ep_tx_pkg.sv
package ep_tx_pkg;

  // Strobes from the control unit to the bank datapath
  typedef struct packed {
    logic wrByte;   // store one firmware byte in wrBank
    logic wrBank;
    logic arm;      // capture byte count of armBank, rewind its write pointer
    logic armBank;
    logic rdStart;  // rewind the read index
    logic rdAdv;    // step the read index
    logic rdBank;   // bank presented on the read side
  } epStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } txState_t;

endpackage

// File: rtl/ep_tx_datapath.sv
module ep_tx_datapath
  import ep_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  epStrobes_t        stb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [CNT_W-1:0]  curLen,
  output logic              rdLast,
  output logic              lenZero
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int NBANK = 2;

  logic [IDX_W-1:0]  rdIdx;
  logic [CNT_W-1:0]  lenArr [NBANK];
  logic [DATA_W-1:0] bankRd [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : gBank
    logic [DATA_W-1:0] store [DEPTH];
    logic [CNT_W-1:0]  ptr;
    logic [CNT_W-1:0]  len;
    logic              selWr;
    logic              selArm;
    logic              room;

    assign selWr  = stb.wrByte && (stb.wrBank == 1'(b));
    assign selArm = stb.arm && (stb.armBank == 1'(b));
    assign room   = ptr < CNT_W'(DEPTH);

    always_ff @(posedge clk) begin
      if (selWr && room) begin
        store[ptr[IDX_W-1:0]] <= wrData;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ptr <= '0;
        len <= '0;
      end else if (selArm) begin
        len <= ptr;
        ptr <= '0;
      end else if (selWr && room) begin
        ptr <= ptr + CNT_W'(1);
      end
    end

    assign lenArr[b] = len;
    assign bankRd[b] = store[rdIdx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdIdx <= '0;
    end else if (stb.rdStart) begin
      rdIdx <= '0;
    end else if (stb.rdAdv) begin
      rdIdx <= rdIdx + IDX_W'(1);
    end
  end

  assign curLen  = lenArr[stb.rdBank];
  assign rdData  = bankRd[stb.rdBank];
  assign rdLast  = (CNT_W'(rdIdx) + CNT_W'(1)) == curLen;
  assign lenZero = (curLen == '0);

endmodule

// File: rtl/ep_tx_control.sv
module ep_tx_control
  import ep_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       fwWrEn,
  input  logic       fwPktReady,
  input  logic       fwClearTxDone,
  input  logic       busInReq,
  input  logic       busAck,
  input  logic       busTimeout,
  input  logic       rdLast,
  input  logic       lenZero,
  output epStrobes_t stb,
  output logic [1:0] bankReady,
  output logic       txValid,
  output logic       txStart,
  output logic       nakPulse,
  output logic       txDone,
  output logic       armOverflow
);

  txState_t state;
  txState_t stateNext;
  logic     fillBank;
  logic     sendBank;
  logic     armSince;
  logic     armOk;
  logic     armRej;
  logic     accept;
  logic     nakNow;
  logic     complete;

  assign armOk    = fwPktReady && !bankReady[fillBank];
  assign armRej   = fwPktReady && bankReady[fillBank];
  assign accept   = (state == ST_IDLE) && busInReq && bankReady[sendBank];
  assign nakNow   = (state == ST_IDLE) && busInReq && !bankReady[sendBank];
  assign complete = (state == ST_WAIT) && busAck;

  always_comb begin
    stb         = '0;
    stb.wrByte  = fwWrEn && !bankReady[fillBank] && !fwPktReady;
    stb.wrBank  = fillBank;
    stb.arm     = armOk;
    stb.armBank = fillBank;
    stb.rdStart = accept;
    stb.rdAdv   = (state == ST_SEND);
    stb.rdBank  = sendBank;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (accept) stateNext = lenZero ? ST_WAIT : ST_SEND;
      ST_SEND: if (rdLast) stateNext = ST_WAIT;
      ST_WAIT: if (busAck || busTimeout) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      bankReady   <= '0;
      fillBank    <= 1'b0;
      sendBank    <= 1'b0;
      txDone      <= 1'b0;
      armSince    <= 1'b0;
      armOverflow <= 1'b0;
      nakPulse    <= 1'b0;
      txStart     <= 1'b0;
    end else begin
      state    <= stateNext;
      nakPulse <= nakNow;
      txStart  <= accept;
      for (int b = 0; b < 2; b++) begin
        if (complete && (sendBank == 1'(b))) bankReady[b] <= 1'b0;
        else if (armOk && (fillBank == 1'(b))) bankReady[b] <= 1'b1;
      end
      if (armOk) fillBank <= ~fillBank;
      if (complete) sendBank <= ~sendBank;
      if (armRej) armOverflow <= 1'b1;
      if (complete) begin
        txDone   <= 1'b1;
        armSince <= armOk;
      end else begin
        if (armOk) armSince <= 1'b1;
        if (fwClearTxDone && armSince) txDone <= 1'b0;
      end
    end
  end

  assign txValid = (state == ST_SEND);

  AST_NAK_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    nakPulse |-> (!txValid && $past(bankReady) == 2'b00)); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (fwPktReady && bankReady == 2'b11 && !busAck) |=> $stable(bankReady) && armOverflow); // R3

  AST_RETRY_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && busTimeout && !busAck) |=> (bankReady[sendBank] && state == ST_IDLE)); // R8

  AST_DONE_ON_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && busAck) |=> (txDone && state == ST_IDLE)); // R7

  AST_CLEAR_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txDone) |-> $past(fwClearTxDone)); // R9

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    armOverflow |=> armOverflow); // R3

endmodule

// File: rtl/pingpong_in_ep.sv
module pingpong_in_ep
  import ep_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fwWrEn,
  input  logic [DATA_W-1:0] fwWrData,
  input  logic              fwPktReady,
  input  logic              fwClearTxDone,
  input  logic              busInReq,
  input  logic              busAck,
  input  logic              busTimeout,
  output logic              txStart,
  output logic              txValid,
  output logic [DATA_W-1:0] txData,
  output logic [CNT_W-1:0]  txLen,
  output logic              nakPulse,
  output logic [1:0]        bankReady,
  output logic              txDone,
  output logic              irq,
  output logic              armOverflow
);

  epStrobes_t stb;
  logic       rdLast;
  logic       lenZero;

  ep_tx_control uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .fwWrEn       (fwWrEn),
    .fwPktReady   (fwPktReady),
    .fwClearTxDone(fwClearTxDone),
    .busInReq     (busInReq),
    .busAck       (busAck),
    .busTimeout   (busTimeout),
    .rdLast       (rdLast),
    .lenZero      (lenZero),
    .stb          (stb),
    .bankReady    (bankReady),
    .txValid      (txValid),
    .txStart      (txStart),
    .nakPulse     (nakPulse),
    .txDone       (txDone),
    .armOverflow  (armOverflow)
  );

  ep_tx_datapath #(
    .DATA_W(DATA_W),
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
  ) uData (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wrData (fwWrData),
    .rdData (txData),
    .curLen (txLen),
    .rdLast (rdLast),
    .lenZero(lenZero)
  );

  assign irq = txDone;

  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rstN)
    txStart |-> (txValid == (txLen != '0))); // R6

endmodule

// File: tb/tb_pingpong_in_ep.sv
module tb_pingpong_in_ep;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       fwWrEn = 1'b0;
  logic [7:0] fwWrData = '0;
  logic       fwPktReady = 1'b0;
  logic       fwClearTxDone = 1'b0;
  logic       busInReq = 1'b0;
  logic       busAck = 1'b0;
  logic       busTimeout = 1'b0;
  logic       txStart, txValid, nakPulse, txDone, irq, armOverflow;
  logic [7:0] txData;
  logic [6:0] txLen;
  logic [1:0] bankReady;

  int vectors = 0;
  int miscompares = 0;
  bit running = 1'b0;

  logic [7:0] byteQ[$];
  int         lenQ[$];
  logic [7:0] mMem [2][64];
  int         mLen [2];
  int         mFill = 0;

  always #2 clk = ~clk;

  pingpong_in_ep dut (
    .clk(clk), .rstN(rstN), .fwWrEn(fwWrEn), .fwWrData(fwWrData),
    .fwPktReady(fwPktReady), .fwClearTxDone(fwClearTxDone),
    .busInReq(busInReq), .busAck(busAck), .busTimeout(busTimeout),
    .txStart(txStart), .txValid(txValid), .txData(txData), .txLen(txLen),
    .nakPulse(nakPulse), .bankReady(bankReady), .txDone(txDone), .irq(irq),
    .armOverflow(armOverflow)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: act %0d exp %0d", req, act, exp);
    end
  endtask

  // Monitor: pops expected items as the design produces them
  always @(negedge clk) begin
    if (rstN && running) begin
      if (txStart) begin
        if (lenQ.size() == 0) chk(1'b0, "R4 unexpected start", int'(txLen), -1);
        else begin
          int e;
          e = lenQ.pop_front();
          chk(int'(txLen) == e, "R1 R4 R6 length", int'(txLen), e);
        end
      end
      if (txValid) begin
        if (byteQ.size() == 0) chk(1'b0, "R6 unexpected byte", int'(txData), -1);
        else begin
          logic [7:0] eb;
          eb = byteQ.pop_front();
          chk(txData == eb, "R1 R4 byte", int'(txData), int'(eb));
        end
      end
    end
  end

  task automatic writeByte(input logic [7:0] v);
    fwWrEn = 1'b1;
    fwWrData = v;
    @(negedge clk);
    fwWrEn = 1'b0;
  endtask

  task automatic pulseArm();
    fwPktReady = 1'b1;
    @(negedge clk);
    fwPktReady = 1'b0;
  endtask

  task automatic fillArm(input int n, input logic [7:0] seed);
    int cnt;
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      writeByte(seed + 8'(i));
      if (cnt < 64) begin
        mMem[mFill][cnt] = seed + 8'(i);
        cnt++;
      end
    end
    pulseArm();
    mLen[mFill] = cnt;
    mFill ^= 1;
  endtask

  task automatic startIn(input int bank);
    lenQ.push_back(mLen[bank]);
    for (int i = 0; i < mLen[bank]; i++) byteQ.push_back(mMem[bank][i]);
    busInReq = 1'b1;
    @(negedge clk);
    busInReq = 1'b0;
  endtask

  task automatic drain();
    wait (byteQ.size() == 0 && lenQ.size() == 0);
    @(negedge clk);
  endtask

  task automatic hostAck();
    busAck = 1'b1;
    @(negedge clk);
    busAck = 1'b0;
  endtask

  task automatic clearDone();
    fwClearTxDone = 1'b1;
    @(negedge clk);
    fwClearTxDone = 1'b0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: act %0d exp %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    running = 1'b1;
    @(negedge clk);

    // R2 reset state
    chk(bankReady == 2'b00, "R2 reset bankReady", int'(bankReady), 0);
    chk(irq == 1'b0, "R2 reset irq", int'(irq), 0);
    chk(armOverflow == 1'b0, "R2 reset overflow", int'(armOverflow), 0);
    chk(txValid == 1'b0, "R2 reset txValid", int'(txValid), 0);

    // R5 NAK with nothing armed
    busInReq = 1'b1;
    @(negedge clk);
    busInReq = 1'b0;
    chk(nakPulse == 1'b1, "R5 nak", int'(nakPulse), 1);
    chk(txStart == 1'b0, "R5 no start", int'(txStart), 0);

    // R1 R2 fill both banks in order
    fillArm(5, 8'h10);
    chk(bankReady == 2'b01, "R2 arm bank0", int'(bankReady), 1);
    fillArm(3, 8'h40);
    chk(bankReady == 2'b11, "R1 R2 arm bank1", int'(bankReady), 3);

    // R3 overflow: write and arm with both banks armed
    writeByte(8'hEE);
    pulseArm();
    chk(bankReady == 2'b11, "R3 ready unchanged", int'(bankReady), 3);
    chk(armOverflow == 1'b1, "R3 overflow flag", int'(armOverflow), 1);

    // R4 send bank0, R8 timeout and resend
    startIn(0);
    drain();
    busTimeout = 1'b1;
    @(negedge clk);
    busTimeout = 1'b0;
    chk(bankReady == 2'b11, "R8 still armed", int'(bankReady), 3);
    chk(irq == 1'b0, "R8 no done", int'(irq), 0);
    startIn(0);
    drain();
    hostAck();
    chk(bankReady == 2'b10, "R7 bank0 freed", int'(bankReady), 2);
    chk(irq == 1'b1, "R7 irq set", int'(irq), 1);

    // R9 clear before any new arm is ignored
    clearDone();
    chk(irq == 1'b1, "R9 early clear ignored", int'(irq), 1);

    // R10 arm, then completion and clear in the same cycle
    fillArm(2, 8'h70);
    chk(bankReady == 2'b11, "R11 both armed", int'(bankReady), 3);
    startIn(1);
    drain();
    busAck = 1'b1;
    fwClearTxDone = 1'b1;
    @(negedge clk);
    busAck = 1'b0;
    fwClearTxDone = 1'b0;
    chk(irq == 1'b1, "R10 completion wins", int'(irq), 1);
    chk(bankReady == 2'b01, "R7 bank1 freed", int'(bankReady), 1);
    clearDone();
    chk(irq == 1'b1, "R10 clear needs new arm", int'(irq), 1);

    // bank0 out, then zero-length bank1 armed and flag cleared
    startIn(0);
    drain();
    hostAck();
    chk(bankReady == 2'b00, "R7 all free", int'(bankReady), 0);
    fillArm(0, 8'h00);
    chk(bankReady == 2'b10, "R6 zero-length armed", int'(bankReady), 2);
    clearDone();
    chk(irq == 1'b0, "R9 clear accepted", int'(irq), 0);

    // R6 zero-length packet
    startIn(1);
    drain();
    chk(txValid == 1'b0, "R6 no payload", int'(txValid), 0);
    hostAck();
    chk(irq == 1'b1, "R7 zero-length done", int'(irq), 1);
    chk(bankReady == 2'b00, "R7 zero-length freed", int'(bankReady), 0);

    // R1 cap at 64 bytes, R11 arm other bank during the stream
    fillArm(66, 8'h80);
    startIn(0);
    fillArm(4, 8'hC0);
    chk(txValid == 1'b1, "R11 still streaming", int'(txValid), 1);
    chk(bankReady == 2'b11, "R11 armed mid-stream", int'(bankReady), 3);
    drain();
    hostAck();
    chk(bankReady == 2'b10, "R11 bank1 remains", int'(bankReady), 2);
    startIn(1);
    drain();
    hostAck();
    chk(bankReady == 2'b00, "R7 final free", int'(bankReady), 0);

    // R5 NAK again once idle
    busInReq = 1'b1;
    @(negedge clk);
    busInReq = 1'b0;
    chk(nakPulse == 1'b1, "R5 nak idle", int'(nakPulse), 1);
    chk(armOverflow == 1'b1, "R3 overflow sticky", int'(armOverflow), 1);

    repeat (2) @(negedge clk);
    chk(byteQ.size() == 0, "R4 bytes left", byteQ.size(), 0);
    chk(lenQ.size() == 0, "R4 packets left", lenQ.size(), 0);

    summary();
    $finish;
  end

endmodule